// File: doc/BRIEF.md
# Two-Phase Load Station

This block is a single load entry for an out-of-order core, with a small private data memory. When a load is issued, its base register comes with it in one of two forms. It is either a finished value, or the tag of the station that will produce it. A pending base is picked up from the result broadcast bus when a broadcast carries the matching tag.

Once the base is present, execution runs in two separate phases. The first phase adds the offset to the base to form the effective address. The second phase reads the memory word at that address. The entry then raises a request on the broadcast bus with its own destination tag and the loaded word. It holds that request until the bus arbiter grants it, and then returns to idle.

The memory is loaded through a separate write port, which the testbench uses to set up contents before running loads.

Top module: `ld_station`

## Requirements
- R1: After a synchronous reset, `busy` and `bc_req` are low.
- R2: A load issued with base tag 0 is accepted using `iss_base_val` as the base, and `bc_req` goes high in the third cycle after the issue edge.
- R3: A load issued with a nonzero base tag and no matching broadcast waits. While it waits, the address stays invalid, `bc_req` stays low, `busy` stays high, and broadcasts carrying other tags are ignored.
- R4: A waiting load captures `bus_data` when `bus_valid` is high and `bus_tag` equals its base tag. It uses that value as the base, and `bc_req` goes high in the third cycle after the capture edge.
- R5: If a matching broadcast is on the bus in the same cycle as the issue, the base is captured at once, and the timing is the same as in R2.
- R6: The memory word read is the one whose index is the low 8 bits of base + offset, computed modulo 2^32, so carries out of the index are discarded.
- R7: `bc_req` stays high, with `bc_tag` and `bc_data` stable, until a cycle in which `bc_gnt` is high. In the cycle after that grant, `busy` and `bc_req` are low.
- R8: An issue presented while `busy` is high is ignored. The load already in the entry completes unchanged, and no extra request follows.
- R9: `bc_tag` equals the destination tag given at issue.
- R10: A write on the init port stores `init_data` at word `init_addr`, and later loads that read that word return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue strobe, taken when not busy |
| iss_base_val | input | DATA_W | Base value when the base tag is 0 |
| iss_base_tag | input | TAG_W | Producer tag of the base, 0 = value present |
| iss_offset | input | DATA_W | Address offset |
| iss_dest_tag | input | TAG_W | Tag this load announces |
| busy | output | 1 | Entry is occupied |
| bus_valid | input | 1 | Broadcast bus carries a result |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_data | input | DATA_W | Broadcast result value |
| bc_req | output | 1 | Request to broadcast |
| bc_tag | output | TAG_W | Tag being broadcast |
| bc_data | output | DATA_W | Loaded word being broadcast |
| bc_gnt | input | 1 | Grant from the bus arbiter |
| init_we | input | 1 | Memory initialization write enable |
| init_addr | input | $clog2(MEM_DEPTH) | Memory initialization word index |
| init_data | input | DATA_W | Memory initialization data |

## Verification
The bench uses the default parameters: 32-bit data, 4-bit tags and a 256-word memory. It fills the whole memory, so a sum that wraps past the top index, or lands exactly on word 255, returns a known and distinct word. The 4-bit tag leaves fifteen producer tags. That is enough to put both a non-matching and a matching broadcast in front of a waiting load, and to offer a second issue with a different destination tag while the entry is busy.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ADDR  = 3'd2,
    ST_MEM   = 3'd3,
    ST_BCAST = 3'd4
  } ld_state_e;
endpackage

// File: rtl/ld_mem.sv
module ld_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/ld_base_slot.sv
module ld_base_slot #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] iss_val,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              direct,
  output logic              capture,
  output logic [DATA_W-1:0] base_val
);
  logic [TAG_W-1:0] pend_tag;
  logic             iss_hit;

  assign iss_hit = bus_valid && (bus_tag == iss_tag);
  assign direct  = (iss_tag == '0) || iss_hit;
  assign capture = (pend_tag != '0) && bus_valid && (bus_tag == pend_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_tag <= '0;
      base_val <= '0;
    end else if (load) begin
      if (iss_tag == '0) begin
        base_val <= iss_val;
        pend_tag <= '0;
      end else if (iss_hit) begin
        base_val <= bus_data;
        pend_tag <= '0;
      end else begin
        pend_tag <= iss_tag;
      end
    end else if (capture) begin
      base_val <= bus_data;
      pend_tag <= '0;
    end
  end
endmodule

// File: rtl/ld_agu.sv
module ld_agu #(
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] iss_offset,
  input  logic              calc,
  input  logic              clr,
  input  logic [DATA_W-1:0] base_val,
  output logic [AW-1:0]     addr,
  output logic              addr_valid
);
  logic [DATA_W-1:0] off_q;
  logic [DATA_W-1:0] sum;

  assign sum = base_val + off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q      <= '0;
      addr       <= '0;
      addr_valid <= 1'b0;
    end else begin
      if (load) begin
        off_q      <= iss_offset;
        addr_valid <= 1'b0;
      end else if (calc) begin
        addr       <= sum[AW-1:0];
        addr_valid <= 1'b1;
      end else if (clr) begin
        addr_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ld_fsm.sv
module ld_fsm
  import ld_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fire,
  input  logic      direct,
  input  logic      capture,
  input  logic      gnt,
  output ld_state_e st
);
  ld_state_e st_n;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (fire) st_n = direct ? ST_ADDR : ST_WAIT;
      ST_WAIT:  if (capture) st_n = ST_ADDR;
      ST_ADDR:  st_n = ST_MEM;
      ST_MEM:   st_n = ST_BCAST;
      ST_BCAST: if (gnt) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_n;
  end
endmodule

// File: rtl/ld_station.sv
module ld_station
  import ld_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  parameter int MEM_DEPTH = 256,
  localparam int AW       = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [DATA_W-1:0] iss_base_val,
  input  logic [TAG_W-1:0]  iss_base_tag,
  input  logic [DATA_W-1:0] iss_offset,
  input  logic [TAG_W-1:0]  iss_dest_tag,
  output logic              busy,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              bc_req,
  output logic [TAG_W-1:0]  bc_tag,
  output logic [DATA_W-1:0] bc_data,
  input  logic              bc_gnt,
  input  logic              init_we,
  input  logic [AW-1:0]     init_addr,
  input  logic [DATA_W-1:0] init_data
);
  ld_state_e         st_q;
  logic              fire;
  logic              direct;
  logic              capture;
  logic [DATA_W-1:0] base_val;
  logic [AW-1:0]     addr;
  logic              addr_valid;
  logic              waiting_base;
  logic [TAG_W-1:0]  dest_q;

  assign busy         = (st_q != ST_IDLE);
  assign fire         = iss_valid && !busy;
  assign bc_req       = (st_q == ST_BCAST);
  assign waiting_base = (st_q == ST_WAIT);
  assign bc_tag       = dest_q;

  always_ff @(posedge clk) begin
    if (rst)       dest_q <= '0;
    else if (fire) dest_q <= iss_dest_tag;
  end

  ld_base_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_base (
    .clk(clk), .rst(rst), .load(fire),
    .iss_val(iss_base_val), .iss_tag(iss_base_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .direct(direct), .capture(capture), .base_val(base_val)
  );

  ld_agu #(.DATA_W(DATA_W), .AW(AW)) u_agu (
    .clk(clk), .rst(rst), .load(fire), .iss_offset(iss_offset),
    .calc(st_q == ST_ADDR), .clr(bc_req && bc_gnt),
    .base_val(base_val), .addr(addr), .addr_valid(addr_valid)
  );

  ld_fsm u_fsm (
    .clk(clk), .rst(rst), .fire(fire), .direct(direct),
    .capture(capture), .gnt(bc_gnt), .st(st_q)
  );

  ld_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .we(init_we), .waddr(init_addr), .wdata(init_data),
    .re((st_q == ST_MEM) && addr_valid), .raddr(addr), .rdata(bc_data)
  );
endmodule

// File: rtl/ld_station_chk.sv
module ld_station_chk #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid,
  input logic [TAG_W-1:0]  iss_base_tag,
  input logic              busy,
  input logic              bc_req,
  input logic [TAG_W-1:0]  bc_tag,
  input logic [DATA_W-1:0] bc_data,
  input logic              bc_gnt,
  input logic              addr_valid,
  input logic              waiting_base
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !bc_req));

  a_r2_ready_latency: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !busy && iss_base_tag == '0) |=> ##2 bc_req);

  a_r3_addr_gated: assert property (@(posedge clk) disable iff (rst)
    waiting_base |-> !addr_valid);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (bc_req && !bc_gnt) |=> (bc_req && $stable(bc_tag) && $stable(bc_data)));

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (bc_req && bc_gnt) |=> (!busy && !bc_req));

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !(bc_req && bc_gnt)) |=> busy);
endmodule

bind ld_station ld_station_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_base_tag(iss_base_tag),
  .busy(busy), .bc_req(bc_req), .bc_tag(bc_tag), .bc_data(bc_data),
  .bc_gnt(bc_gnt), .addr_valid(addr_valid), .waiting_base(waiting_base)
);

// File: tb/ld_station_bench.sv
module ld_station_bench;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 0;
  logic rst = 1;
  logic iss_valid = 0;
  logic [DW-1:0] iss_base_val = '0;
  logic [TW-1:0] iss_base_tag = '0;
  logic [DW-1:0] iss_offset = '0;
  logic [TW-1:0] iss_dest_tag = '0;
  logic busy;
  logic bus_valid = 0;
  logic [TW-1:0] bus_tag = '0;
  logic [DW-1:0] bus_data = '0;
  logic bc_req;
  logic [TW-1:0] bc_tag;
  logic [DW-1:0] bc_data;
  logic bc_gnt = 0;
  logic init_we = 0;
  logic [AW-1:0] init_addr = '0;
  logic [DW-1:0] init_data = '0;

  always #4 clk = ~clk;

  ld_station u_ld_station (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_base_val(iss_base_val),
    .iss_base_tag(iss_base_tag), .iss_offset(iss_offset), .iss_dest_tag(iss_dest_tag),
    .busy(busy), .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .bc_req(bc_req), .bc_tag(bc_tag), .bc_data(bc_data), .bc_gnt(bc_gnt),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data)
  );

  typedef struct {
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
    string         rq;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  int gnt_delay = 0;
  bit finished = 0;

  task automatic chk(bit ok, string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] pattern(int a);
    logic [7:0] b;
    b = 8'(a);
    return {b, ~b, b ^ 8'h5A, b + 8'd3};
  endfunction

  task automatic mem_write(int a, logic [DW-1:0] d);
    @(negedge clk);
    init_we = 1; init_addr = AW'(a); init_data = d;
    @(negedge clk);
    init_we = 0;
    model[a] = d;
  endtask

  // Scoreboard monitor: pops expected items when a request starts, grants after gnt_delay
  logic          req_d = 0;
  logic          gnt_d = 0;
  logic [TW-1:0] held_tag;
  logic [DW-1:0] held_data;
  int            hold_cnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (gnt_d) begin
        chk(!busy && !bc_req, "R7 release after grant", {31'd0, busy | bc_req}, 0);
      end
      gnt_d = bc_gnt;
      if (bc_req) begin
        if (!req_d) begin
          if (sb.size() == 0) begin
            chk(0, "R8 unexpected request", {28'd0, bc_tag}, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(bc_tag == e.tag, {e.rq, " R9 tag"}, {28'd0, bc_tag}, {28'd0, e.tag});
            chk(bc_data == e.data, {e.rq, " data"}, bc_data, e.data);
          end
          hold_cnt = 0;
          held_tag = bc_tag;
          held_data = bc_data;
        end else begin
          chk(bc_tag == held_tag && bc_data == held_data, "R7 hold stable", bc_data, held_data);
        end
        bc_gnt = (hold_cnt >= gnt_delay);
        hold_cnt++;
      end else begin
        bc_gnt = 0;
      end
      req_d = bc_req;
    end
  end

  // Issue and count negedges: request must appear exactly on the third
  task automatic expect_latency(string rq, bit clr_iss, bit clr_bus);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (clr_iss) iss_valid = 0;
        if (clr_bus) bus_valid = 0;
      end
      if (k < 3) chk(!bc_req, {rq, " early request"}, {31'd0, bc_req}, 0);
      else       chk(bc_req, {rq, " request cycle"}, {31'd0, bc_req}, 1);
    end
  endtask

  task automatic drive_issue(logic [DW-1:0] b, logic [TW-1:0] bt, logic [DW-1:0] o, logic [TW-1:0] d);
    iss_valid = 1; iss_base_val = b; iss_base_tag = bt; iss_offset = o; iss_dest_tag = d;
  endtask

  task automatic push(logic [TW-1:0] d, logic [DW-1:0] b, logic [DW-1:0] o, string rq);
    exp_t e;
    logic [DW-1:0] s;
    s = b + o;
    e.tag = d;
    e.data = model[s[AW-1:0]];
    e.rq = rq;
    sb.push_back(e);
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((busy || sb.size() != 0) && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(!busy && sb.size() == 0, "R7 entry returns idle", {31'd0, busy}, 0);
  endtask

  task automatic ready_load(logic [DW-1:0] b, logic [DW-1:0] o, logic [TW-1:0] d, string rq);
    @(negedge clk);
    push(d, b, o, rq);
    drive_issue(b, '0, o, d);
    expect_latency(rq, 1, 0);
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(!busy && !bc_req, "R1 reset state", {31'd0, busy | bc_req}, 0);

    for (int a = 0; a < DEPTH; a++) mem_write(a, pattern(a));

    // R2: ready base, zero grant delay
    ready_load(32'h0000_0100, 32'h0000_0010, 4'd3, "R2 ready base");
    // R6: wrap of base+offset past word 255, and exact top word
    ready_load(32'hFFFF_FFF0, 32'h0000_0025, 4'd4, "R6 wrap");
    ready_load(32'h1234_5600, 32'h0000_02FF, 4'd5, "R6 top word");

    // R3 and R4: pending tag, foreign broadcasts ignored, then matching capture
    @(negedge clk);
    push(4'd6, 32'h0000_0040, 32'h0000_0002, "R4 captured base");
    drive_issue(32'hDEAD_0000, 4'd5, 32'h0000_0002, 4'd6);
    @(negedge clk);
    iss_valid = 0;
    for (int k = 0; k < 4; k++) begin
      bus_valid = 1; bus_tag = 4'(k + 1); bus_data = 32'h0000_0077;
      @(negedge clk);
      chk(busy && !bc_req, "R3 waits on foreign tag", {31'd0, bc_req}, 0);
    end
    bus_valid = 1; bus_tag = 4'd5; bus_data = 32'h0000_0040;
    expect_latency("R4", 0, 1);
    wait_idle();

    // R5: matching broadcast in the issue cycle, with grant delay for R7
    gnt_delay = 3;
    @(negedge clk);
    push(4'd9, 32'h0000_00A0, 32'h0000_0001, "R5 same-cycle capture");
    drive_issue(32'h0, 4'd7, 32'h0000_0001, 4'd9);
    bus_valid = 1; bus_tag = 4'd7; bus_data = 32'h0000_00A0;
    expect_latency("R5", 1, 1);
    wait_idle();
    gnt_delay = 0;

    // R8: issue while busy is ignored
    @(negedge clk);
    push(4'd2, 32'h0000_0011, 32'h0000_0000, "R8 original load");
    drive_issue(32'h0, 4'd9, 32'h0, 4'd2);
    @(negedge clk);
    drive_issue(32'h0000_0033, 4'd0, 32'h0, 4'd12);
    repeat (2) @(negedge clk);
    iss_valid = 0;
    chk(busy && !bc_req, "R8 still waiting", {31'd0, bc_req}, 0);
    bus_valid = 1; bus_tag = 4'd9; bus_data = 32'h0000_0011;
    expect_latency("R8", 0, 1);
    wait_idle();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!busy && !bc_req, "R8 no extra request", {31'd0, busy | bc_req}, 0);
    end

    // R10: rewrite a word and read it back
    mem_write(8'h42, 32'hCAFE_F00D);
    ready_load(32'h0000_0040, 32'h0000_0002, 4'd15, "R10 init write");

    summary();
  end
endmodule